// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

A general-purpose I/O port driven from a simple 32-bit register bus. Software changes output levels and driver enables without read-modify-write cycles: four write-only registers each act only on the pins whose write-data bit is one. One register raises output bits and one lowers them. One register turns pin drivers on and one returns pins to high impedance. A fifth, read-only register returns the pin levels after a synchronizer.

The write and read channels are independent, so a write and a read may be issued in the same cycle. Read data is registered and appears one cycle after the read strobe. Bit n of every word belongs to pin n. Bits at or above `PIN_COUNT` are dropped on writes and read back as zero.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset, `pin_out` and `pin_oe` are all zero (every pin in high impedance), and `rd_data` is zero.
- R2: A write to offset 0x00 sets each `pin_out` bit whose `wr_data` bit is one. Bits written as zero keep their value.
- R3: A write to offset 0x10 clears each `pin_out` bit whose `wr_data` bit is one. Bits written as zero keep their value.
- R4: A write to offset 0x20 sets each `pin_oe` bit (driver on) whose `wr_data` bit is one. Bits written as zero keep their value.
- R5: A write to offset 0x30 clears each `pin_oe` bit (high impedance) whose `wr_data` bit is one. Bits written as zero keep their value.
- R6: A read of offset 0x40 returns the synchronized pin levels, with bit n equal to pin n, on `rd_data` in the cycle after the `rd_en` edge.
- R7: Pin levels pass through two flops. A read sampled on the first or second rising edge after a pin change returns the old level, and a read sampled on the third edge returns the new level.
- R8: A read of any offset other than 0x40, including the four write-only offsets, returns zero.
- R9: A write to offset 0x40, or to any unmapped offset, changes neither `pin_out` nor `pin_oe`.
- R10: While `wr_en` is low, `pin_out` and `pin_oe` hold, whatever is on `wr_addr` and `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data, bit n acts on pin n |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Registered read data |
| pin_in | input | PIN_COUNT | Asynchronous pin levels |
| pin_out | output | PIN_COUNT | Output latch, drives pad data |
| pin_oe | output | PIN_COUNT | Per-pin driver enable; 0 = high impedance |

## Verification
Two things can fall in the same cycle: a pin-level change and a level read that is already in flight. The bench changes `pin_in` on the same falling edge on which it raises a read strobe at 0x40, then holds the strobe for three edges. It expects the old level after the first and second edges and the new level after the third. A table of writes then alternates set, clear, enable, release and ignored writes, comparing both latches after each entry.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
   localparam int OFF_SET = 'h00;
   localparam int OFF_CLR = 'h10;
   localparam int OFF_EN  = 'h20;
   localparam int OFF_REL = 'h30;
   localparam int OFF_LVL = 'h40;
   localparam int BUS_W   = 32;

   typedef enum logic [2:0] {
      WK_NONE,
      WK_SET,
      WK_CLR,
      WK_EN,
      WK_REL
   } wr_kind_e;
endpackage

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("gpio_sc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage[i] <= '0;
      end else begin
         stage[0] <= d_async;
         for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
      end
   end

   assign q_sync = stage[STAGES-1];
endmodule

// File: rtl/gpio_sc_latch_bank.sv
module gpio_sc_latch_bank #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_stb,
   input  logic             clr_stb,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)       q <= '0;
      else if (clr_stb) q <= q & ~mask;
      else if (set_stb) q <= q | mask;
   end

   // R2 / R4: ones in the mask end up high
   a_r2_set_bits_high: assert property (@(posedge clk) disable iff (!rst_n)
      (set_stb && !clr_stb) |=> ((q & $past(mask)) == $past(mask)));
   // R3 / R5: ones in the mask end up low
   a_r3_clr_bits_low: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |=> ((q & $past(mask)) == '0));
   // R2..R5: zero mask bits keep their value
   a_r4_zero_bits_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (set_stb || clr_stb) |=> ((q & ~$past(mask)) == ($past(q) & ~$past(mask))));
   // R10: no strobe, no change
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_stb && !clr_stb) |=> $stable(q));
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
   import gpio_sc_pkg::*;
#(
   parameter int PIN_COUNT   = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [31:0]          wr_data,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [31:0]          rd_data,
   input  logic [PIN_COUNT-1:0] pin_in,
   output logic [PIN_COUNT-1:0] pin_out,
   output logic [PIN_COUNT-1:0] pin_oe
);
   generate
      if (PIN_COUNT < 1 || PIN_COUNT > BUS_W) begin : g_bad_pins
         $error("gpio_setclr_port: PIN_COUNT must be 1..32");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("gpio_setclr_port: ADDR_W too narrow for offset 0x40");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFF_SET);
   localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFF_CLR);
   localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFF_EN);
   localparam logic [ADDR_W-1:0] A_REL = ADDR_W'(OFF_REL);
   localparam logic [ADDR_W-1:0] A_LVL = ADDR_W'(OFF_LVL);

   wr_kind_e               kind;
   logic [PIN_COUNT-1:0]   wmask;
   logic [PIN_COUNT-1:0]   lvl_sync;

   always_comb begin
      kind = WK_NONE;
      if (wr_en) begin
         case (wr_addr)
            A_SET:   kind = WK_SET;
            A_CLR:   kind = WK_CLR;
            A_EN:    kind = WK_EN;
            A_REL:   kind = WK_REL;
            default: kind = WK_NONE;
         endcase
      end
   end

   assign wmask = wr_data[PIN_COUNT-1:0];

   gpio_sc_latch_bank #(.WIDTH(PIN_COUNT)) u_out_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (kind == WK_SET),
      .clr_stb (kind == WK_CLR),
      .mask    (wmask),
      .q       (pin_out)
   );

   gpio_sc_latch_bank #(.WIDTH(PIN_COUNT)) u_oe_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (kind == WK_EN),
      .clr_stb (kind == WK_REL),
      .mask    (wmask),
      .q       (pin_oe)
   );

   gpio_sc_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in),
      .q_sync  (lvl_sync)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        rd_data <= '0;
      else if (rd_en)    rd_data <= (rd_addr == A_LVL) ? 32'(lvl_sync) : '0;
   end

   // R6: level read returns the synchronizer output
   a_r6_level_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == A_LVL) |=> (rd_data == 32'($past(lvl_sync))));
   // R8: other offsets read as zero
   a_r8_other_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr != A_LVL) |=> (rd_data == '0));
   // R9: writes to the level or unmapped offsets touch no latch
   a_r9_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != A_SET && wr_addr != A_CLR && wr_addr != A_EN
       && wr_addr != A_REL) |=> ($stable(pin_out) && $stable(pin_oe)));
   // R10: idle write channel holds both latches
   a_r10_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/gpio_setclr_port_tb.sv
module gpio_setclr_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out;
   logic [31:0] pin_oe;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_setclr_port u_dut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // {addr, wdata, expected pin_out, expected pin_oe}
   localparam logic [103:0] VEC [10] = '{
      {8'h00, 32'hF0F0_00FF, 32'hF0F0_00FF, 32'h0000_0000},
      {8'h10, 32'h0000_00F0, 32'hF0F0_000F, 32'h0000_0000},
      {8'h20, 32'h0000_FFFF, 32'hF0F0_000F, 32'h0000_FFFF},
      {8'h00, 32'h0F00_0000, 32'hFFF0_000F, 32'h0000_FFFF},
      {8'h30, 32'h0000_00FF, 32'hFFF0_000F, 32'h0000_FF00},
      {8'h40, 32'hFFFF_FFFF, 32'hFFF0_000F, 32'h0000_FF00},
      {8'h10, 32'h0000_0000, 32'hFFF0_000F, 32'h0000_FF00},
      {8'h08, 32'hFFFF_FFFF, 32'hFFF0_000F, 32'h0000_FF00},
      {8'h20, 32'hA500_0000, 32'hFFF0_000F, 32'hA500_FF00},
      {8'h10, 32'hFFFF_FFFF, 32'h0000_0000, 32'hA500_FF00}
   };

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_read(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   initial begin
      #400000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "pin_out", pin_out, 32'h0);
      check("R1", "pin_oe", pin_oe, 32'h0);
      check("R1", "rd_data", rd_data, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 10; i++) begin
         string tag;
         case (VEC[i][103:96])
            8'h00:   tag = "R2";
            8'h10:   tag = "R3";
            8'h20:   tag = "R4";
            8'h30:   tag = "R5";
            default: tag = "R9";
         endcase
         do_write(VEC[i][103:96], VEC[i][95:64]);
         check(tag, "pin_out", pin_out, VEC[i][63:32]);
         check(tag, "pin_oe", pin_oe, VEC[i][31:0]);
      end

      // R10: address and data on the bus with wr_en low
      @(negedge clk);
      wr_en = 1'b0; wr_addr = 8'h00; wr_data = 32'hFFFF_FFFF;
      @(negedge clk);
      wr_addr = 8'h30;
      @(negedge clk);
      check("R10", "pin_out", pin_out, 32'h0);
      check("R10", "pin_oe", pin_oe, 32'hA500_FF00);

      // R8: write-only offsets read zero while latches are nonzero
      do_write(8'h00, 32'h0000_FFFF);
      do_read(8'h00, r); check("R8", "read 0x00", r, 32'h0);
      do_read(8'h10, r); check("R8", "read 0x10", r, 32'h0);
      do_read(8'h20, r); check("R8", "read 0x20", r, 32'h0);
      do_read(8'h30, r); check("R8", "read 0x30", r, 32'h0);

      // R6: settled level read, bit n is pin n
      pin_in = 32'h1234_5678;
      repeat (4) @(negedge clk);
      do_read(8'h40, r); check("R6", "level", r, 32'h1234_5678);

      // R7: pin change in the same cycle a level read starts
      @(negedge clk);
      pin_in = 32'h8000_0001; rd_en = 1'b1; rd_addr = 8'h40;
      @(negedge clk);
      check("R7", "edge1 old", rd_data, 32'h1234_5678);
      @(negedge clk);
      check("R7", "edge2 old", rd_data, 32'h1234_5678);
      @(negedge clk);
      check("R7", "edge3 new", rd_data, 32'h8000_0001);
      rd_en = 1'b0;

      // write and read issued together: set takes effect, read still sees level
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'h00; wr_data = 32'h00F0_0000;
      rd_en = 1'b1; rd_addr = 8'h40;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      check("R2", "set with read", pin_out, 32'h00F0_FFFF);
      check("R6", "read with write", rd_data, 32'h8000_0001);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule